// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Device Model

This block is a synthesizable stand-in for a 16-bit asynchronous static RAM whose two bytes have separate enables. It serves as the target device when a memory controller is tested. Its control pins are active low: chip select, output enable, write strobe, and one enable per byte lane. The bidirectional data bus is split into a data input, a data output and one output-enable per lane. A pad wrapper or the bench combines these into tri-state pins.

The model samples all pins on a fast internal clock, one register stage deep. Each lane's drive and each lane's write are decided from the sampled chip select, write strobe, output enable and that lane's enable. A write is the overlap of chip select low and write strobe low. The write is committed when that overlap ends, with the address, data and lane enables seen on the last sampled overlap cycle.

Storage depth is a parameter. Address bits above the depth are ignored, so addresses alias modulo the depth.

Top module: `sram_lane_model`

## Requirements
- R1: After reset no lane is driven (`dout_oe` = 0, `dout` = 0), and every word reads back as zero until it is written.
- R2: While the sampled chip select `ce_n` is high, both lanes are undriven, whatever the other pins are.
- R3: With `ce_n` low, `we_n` high and `oe_n` high, both lanes are undriven.
- R4: With `ce_n` low, `we_n` high and `oe_n` low, lane 0 (data bits 7:0, enable `lane_en_n[0]`) and lane 1 (bits 15:8, enable `lane_en_n[1]`) each drive stored data only when their own enable is low. An undriven lane's `dout` bits read 0. Outputs follow the pins one clock later.
- R5: While `ce_n` and `we_n` are both low, no lane is driven, whatever `oe_n` is.
- R6: A write stores bits 7:0 only if `lane_en_n[0]` is low and bits 15:8 only if `lane_en_n[1]` is low. A disabled lane keeps its old contents.
- R7: A write takes effect only when the overlap of `ce_n` low and `we_n` low ends, whether `ce_n` or `we_n` rises first. It stores the address, data and lane enables of the last sampled overlap cycle. Values changed at or after the end are not stored.
- R8: A write whose final overlap cycle has both lane enables high leaves memory unchanged.
- R9: Only the low log2(DEPTH) address bits select a word. Addresses that differ only above that field reach the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| lane_en_n | input | LANES (2) | Per-lane byte enable, active low; bit 0 is the low byte |
| addr | input | ADDR_W (17) | Word address |
| din | input | DATA_W (16) | Data from the bus during writes |
| dout | output | DATA_W (16) | Read data; zero on undriven lanes |
| dout_oe | output | LANES (2) | Per-lane output drive enable |

## Verification
Random mixes of the four pin states (standby, output disabled, read, write) are applied with random lane enables and addresses. These separate the per-lane truth-table decode from a decode of the whole word. Directed writes do the following:
- change data and enables after a junk first overlap cycle, to show that the last overlap cycle is the one stored;
- end the write by chip select in some cases and by the write strobe in others;
- change the data as the write ends, to catch a commit that samples too late.

A write with both enables high and reads at addresses offset by the depth cover the no-op write and address aliasing.

// File: rtl/sram_model_pkg.sv
package sram_model_pkg;

   typedef enum logic [1:0] {
      MODE_STANDBY = 2'd0,
      MODE_QUIET   = 2'd1,
      MODE_READ    = 2'd2,
      MODE_WRITE   = 2'd3
   } dev_mode_e;

   // Whole-device mode from the three shared controls (active low).
   function automatic dev_mode_e decode_mode(input logic ce_n,
                                             input logic oe_n,
                                             input logic we_n);
      dev_mode_e m;
      if (ce_n)       m = MODE_STANDBY;
      else if (!we_n) m = MODE_WRITE;
      else if (oe_n)  m = MODE_QUIET;
      else            m = MODE_READ;
      return m;
   endfunction

endpackage

// File: rtl/sram_pin_sampler.sv
module sram_pin_sampler #(
   parameter int ADDR_W = 17,
   parameter int DATA_W = 16,
   parameter int LANES  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic [LANES-1:0]  lane_en_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   output logic              s_ce_n,
   output logic              s_oe_n,
   output logic              s_we_n,
   output logic [LANES-1:0]  s_lane_en_n,
   output logic [ADDR_W-1:0] s_addr,
   output logic [DATA_W-1:0] s_din
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_ce_n      <= 1'b1;
         s_oe_n      <= 1'b1;
         s_we_n      <= 1'b1;
         s_lane_en_n <= '1;
         s_addr      <= '0;
         s_din       <= '0;
      end else begin
         s_ce_n      <= ce_n;
         s_oe_n      <= oe_n;
         s_we_n      <= we_n;
         s_lane_en_n <= lane_en_n;
         s_addr      <= addr;
         s_din       <= din;
      end
   end
endmodule

// File: rtl/sram_mode_decode.sv
module sram_mode_decode
   import sram_model_pkg::*;
#(
   parameter int LANES = 2
) (
   input  logic             s_ce_n,
   input  logic             s_oe_n,
   input  logic             s_we_n,
   input  logic [LANES-1:0] s_lane_en_n,
   output dev_mode_e        mode,
   output logic [LANES-1:0] lane_drive,
   output logic             overlap
);
   always_comb mode = decode_mode(s_ce_n, s_oe_n, s_we_n);

   assign overlap = (mode == MODE_WRITE);

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign lane_drive[l] = (mode == MODE_READ) && !s_lane_en_n[l];
   end
endmodule

// File: rtl/sram_write_tracker.sv
module sram_write_tracker #(
   parameter int IDX_W  = 8,
   parameter int DATA_W = 16,
   parameter int LANES  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              overlap,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] din,
   input  logic [LANES-1:0]  lane_en_n,
   output logic              commit,
   output logic [IDX_W-1:0]  cm_idx,
   output logic [DATA_W-1:0] cm_data,
   output logic [LANES-1:0]  cm_lane_en_n
);
   logic ovl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovl_q        <= 1'b0;
         cm_idx       <= '0;
         cm_data      <= '0;
         cm_lane_en_n <= '1;
      end else begin
         ovl_q <= overlap;
         if (overlap) begin
            cm_idx       <= idx;
            cm_data      <= din;
            cm_lane_en_n <= lane_en_n;
         end
      end
   end

   // End of overlap: the write was active last sample and is not now.
   assign commit = ovl_q && !overlap;
endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array #(
   parameter int DEPTH  = 256,
   parameter int LANE_W = 8,
   parameter int LANES  = 2,
   localparam int IDX_W  = $clog2(DEPTH),
   localparam int DATA_W = LANE_W * LANES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              commit,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [LANES-1:0]  wr_lane_en_n,
   input  logic [IDX_W-1:0]  rd_idx,
   input  logic [LANES-1:0]  lane_drive,
   output logic [DATA_W-1:0] rd_data
);
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [LANE_W-1:0] mem [DEPTH];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
         end else if (commit && !wr_lane_en_n[l]) begin
            mem[wr_idx] <= wr_data[l*LANE_W +: LANE_W];
         end
      end

      assign rd_data[l*LANE_W +: LANE_W] = lane_drive[l] ? mem[rd_idx] : '0;
   end
endmodule

// File: rtl/sram_lane_model.sv
module sram_lane_model
   import sram_model_pkg::*;
#(
   parameter int ADDR_W = 17,
   parameter int DEPTH  = 256,
   parameter int LANE_W = 8,
   parameter int LANES  = 2,
   localparam int IDX_W  = $clog2(DEPTH),
   localparam int DATA_W = LANE_W * LANES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic [LANES-1:0]  lane_en_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   output logic [LANES-1:0]  dout_oe
);
   if (DEPTH < 2 || (1 << IDX_W) != DEPTH) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (IDX_W > ADDR_W) begin : g_bad_addr
      $error("DEPTH exceeds the address range");
   end
   if (LANE_W < 1 || LANES < 1) begin : g_bad_lane
      $error("LANE_W and LANES must be positive");
   end

   logic              s_ce_n, s_oe_n, s_we_n;
   logic [LANES-1:0]  s_lane_en_n;
   logic [ADDR_W-1:0] s_addr;
   logic [DATA_W-1:0] s_din;
   dev_mode_e         mode;
   logic [LANES-1:0]  lane_drive;
   logic              overlap;
   logic              wr_commit;
   logic [IDX_W-1:0]  cm_idx;
   logic [DATA_W-1:0] cm_data;
   logic [LANES-1:0]  cm_lane_en_n;
   logic [IDX_W-1:0]  s_idx;

   assign s_idx = s_addr[IDX_W-1:0];

   sram_pin_sampler #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_smp (
      .clk(clk), .rst_n(rst_n),
      .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .lane_en_n(lane_en_n),
      .addr(addr), .din(din),
      .s_ce_n(s_ce_n), .s_oe_n(s_oe_n), .s_we_n(s_we_n),
      .s_lane_en_n(s_lane_en_n), .s_addr(s_addr), .s_din(s_din)
   );

   sram_mode_decode #(.LANES(LANES)) u_dec (
      .s_ce_n(s_ce_n), .s_oe_n(s_oe_n), .s_we_n(s_we_n),
      .s_lane_en_n(s_lane_en_n),
      .mode(mode), .lane_drive(lane_drive), .overlap(overlap)
   );

   sram_write_tracker #(.IDX_W(IDX_W), .DATA_W(DATA_W), .LANES(LANES)) u_trk (
      .clk(clk), .rst_n(rst_n), .overlap(overlap),
      .idx(s_idx), .din(s_din), .lane_en_n(s_lane_en_n),
      .commit(wr_commit), .cm_idx(cm_idx), .cm_data(cm_data),
      .cm_lane_en_n(cm_lane_en_n)
   );

   sram_lane_array #(.DEPTH(DEPTH), .LANE_W(LANE_W), .LANES(LANES)) u_arr (
      .clk(clk), .rst_n(rst_n), .commit(wr_commit),
      .wr_idx(cm_idx), .wr_data(cm_data), .wr_lane_en_n(cm_lane_en_n),
      .rd_idx(s_idx), .lane_drive(lane_drive), .rd_data(dout)
   );

   assign dout_oe = lane_drive;
endmodule

// File: rtl/sram_lane_model_chk.sv
module sram_lane_model_chk #(
   parameter int LANES = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ce_n,
   input logic             oe_n,
   input logic             we_n,
   input logic [LANES-1:0] lane_en_n,
   input logic [LANES-1:0] dout_oe,
   input logic             wr_commit
);
   logic [1:0] age;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         age <= 2'd0;
      else if (age != 2'd3) age <= age + 2'd1;
   end

   AST_STANDBY_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      (age != 0) && $past(ce_n) |-> dout_oe == '0); // R2

   AST_QUIET_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      (age != 0) && !$past(ce_n) && $past(we_n) && $past(oe_n) |-> dout_oe == '0); // R3

   AST_WRITE_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      (age != 0) && !$past(ce_n) && !$past(we_n) |-> dout_oe == '0); // R5

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      AST_LANE_READ_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
         (age != 0) && !$past(ce_n) && $past(we_n) && !$past(oe_n)
         |-> dout_oe[l] == !$past(lane_en_n[l])); // R4
   end

   AST_COMMIT_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2) && wr_commit
      |-> ($past(ce_n) || $past(we_n)) && !$past(ce_n, 2) && !$past(we_n, 2)); // R7
endmodule

bind sram_lane_model sram_lane_model_chk #(.LANES(LANES)) u_chk (
   .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
   .lane_en_n(lane_en_n), .dout_oe(dout_oe), .wr_commit(wr_commit)
);

// File: tb/sram_lane_model_tb_top.sv
module sram_lane_model_tb_top;
   localparam int ADDR_W = 17;
   localparam int DEPTH  = 256;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
   logic [1:0]        lane_en_n = 2'b11;
   logic [ADDR_W-1:0] addr = '0;
   logic [15:0]       din = '0;
   logic [15:0]       dout;
   logic [1:0]        dout_oe;

   int n_vec = 0;
   int n_bad = 0;
   bit finished = 1'b0;
   logic [15:0] ref_mem [DEPTH];

   always #5 clk = ~clk;

   sram_lane_model #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) dut_i (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .lane_en_n(lane_en_n), .addr(addr), .din(din),
      .dout(dout), .dout_oe(dout_oe)
   );

   function automatic int widx(input logic [ADDR_W-1:0] a);
      return int'(a % DEPTH);
   endfunction

   function automatic logic [15:0] exp_read(input logic [ADDR_W-1:0] a, input logic [1:0] be_n);
      logic [15:0] w = ref_mem[widx(a)];
      return {be_n[1] ? 8'h00 : w[15:8], be_n[0] ? 8'h00 : w[7:0]};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_read(input string req, input logic [ADDR_W-1:0] a,
                          input logic [1:0] be_n, input logic oe);
      @(negedge clk);
      ce_n = 1'b0; we_n = 1'b1; oe_n = oe; addr = a; lane_en_n = be_n;
      din = 16'($urandom);
      @(negedge clk);
      chk(req, {30'd0, dout_oe}, oe ? 32'd0 : {30'd0, ~be_n});
      chk(req, {16'd0, dout}, oe ? 32'd0 : {16'd0, exp_read(a, be_n)});
   endtask

   // R7: first overlap cycle carries junk; the last overlap cycle's values are stored.
   task automatic do_write(input logic [ADDR_W-1:0] a, input logic [15:0] d,
                           input logic [1:0] be_n, input bit by_ce, input logic oe);
      @(negedge clk);
      ce_n = 1'b0; we_n = 1'b0; oe_n = oe;
      addr = ADDR_W'($urandom); din = 16'($urandom); lane_en_n = 2'b00;
      @(negedge clk);
      addr = a; din = d; lane_en_n = be_n;
      @(negedge clk);
      chk("R5", {30'd0, dout_oe}, 32'd0);
      if (by_ce) ce_n = 1'b1; else we_n = 1'b1;
      din = ~d; lane_en_n = ~be_n; addr = ADDR_W'($urandom);
      @(negedge clk);
      ce_n = 1'b1; we_n = 1'b1;
      @(negedge clk);
      if (!be_n[0]) ref_mem[widx(a)][7:0]  = d[7:0];
      if (!be_n[1]) ref_mem[widx(a)][15:8] = d[15:8];
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog actual=timeout expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240917));
      for (int i = 0; i < DEPTH; i++) ref_mem[i] = 16'h0000;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk("R1", {30'd0, dout_oe}, 32'd0);
      chk("R1", {16'd0, dout}, 32'd0);
      do_read("R1", 17'h00005, 2'b00, 1'b0);
      do_read("R1", 17'h000FF, 2'b00, 1'b0);

      // R6: full, low-only, high-only writes
      do_write(17'h00010, 16'hA5C3, 2'b00, 1'b0, 1'b1);
      do_read("R6", 17'h00010, 2'b00, 1'b0);
      do_write(17'h00010, 16'h1122, 2'b10, 1'b0, 1'b0);
      do_read("R6", 17'h00010, 2'b00, 1'b0);
      do_write(17'h00010, 16'h3344, 2'b01, 1'b1, 1'b1);
      do_read("R6", 17'h00010, 2'b00, 1'b0);
      // R4: single-lane reads
      do_read("R4", 17'h00010, 2'b10, 1'b0);
      do_read("R4", 17'h00010, 2'b01, 1'b0);
      do_read("R4", 17'h00010, 2'b11, 1'b0);
      // R3: output disabled
      do_read("R3", 17'h00010, 2'b00, 1'b1);
      // R8: write with both lanes disabled
      do_write(17'h00010, 16'hDEAD, 2'b11, 1'b0, 1'b1);
      do_read("R8", 17'h00010, 2'b00, 1'b0);
      // R7: write terminated by chip select
      do_write(17'h00033, 16'hBEEF, 2'b00, 1'b1, 1'b0);
      do_read("R7", 17'h00033, 2'b00, 1'b0);
      // R9: aliasing above the depth
      do_write(17'h10020, 16'h5A5A, 2'b00, 1'b0, 1'b1);
      do_read("R9", 17'h00020, 2'b00, 1'b0);
      do_read("R9", ADDR_W'(17'h00020 + 3 * DEPTH), 2'b00, 1'b0);
      // R2: standby with read-like pins
      @(negedge clk);
      ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b0; lane_en_n = 2'b00; addr = 17'h00020;
      @(negedge clk);
      chk("R2", {30'd0, dout_oe}, 32'd0);
      chk("R2", {16'd0, dout}, 32'd0);

      for (int k = 0; k < 400; k++) begin
         logic [ADDR_W-1:0] a = ADDR_W'($urandom);
         logic [1:0] be = 2'($urandom);
         case ($urandom % 4)
            0: do_write(a, 16'($urandom), be, 1'($urandom), 1'($urandom));
            1: do_read("R4", a, be, 1'b0);
            2: do_read("R3", a, be, 1'b1);
            default: begin
               @(negedge clk);
               ce_n = 1'b1; we_n = 1'($urandom); oe_n = 1'($urandom);
               lane_en_n = be; addr = a; din = 16'($urandom);
               @(negedge clk);
               chk("R2", {30'd0, dout_oe}, 32'd0);
            end
         endcase
      end

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule